// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a predicate selector into a per-element enable mask for a vector operation. A one-bit mode chooses between two mask sources. Integer mode takes snapshots of three general registers (r3, r10 and r30). Condition mode takes, for every element i, the four flag bits of the condition field at index 32 + i. Within the chosen mode, a 3-bit code picks which source bit to test and whether to invert it. One further integer code enables a single element, chosen by number.

Twin predication uses two independent mask lanes, one for the destination and one for the source. The lanes share the mode, the vector length and the register snapshots, and each lane has its own code. A one-cycle request strobe loads both lane registers and raises the valid flag on the next clock. Between requests the masks keep their values. Reading the register files and writing back condition fields are done outside this block, which only receives the needed values on its inputs.

Top module: `pred_mask_gen`

## Requirements
- R1: While reset is high, and after it, until the first request: valid_o is 0 and both masks are all zeros.
- R2: valid_o is 1 in exactly the cycle after a cycle with req_i high, and 0 otherwise. The masks update only at a clock edge where req_i is high, and otherwise hold their value.
- R3: With mode 0 (integer) and code 000, every element below the vector length is enabled.
- R4: With mode 0 and code 001, only element i where i equals r3 is enabled. An r3 value of 64 or more enables no element.
- R5: With mode 0, codes 010 and 011 use bit i of r3, codes 100 and 101 use bit i of r10, and codes 110 and 111 use bit i of r30. An odd code inverts the bit.
- R6: With mode 1 (condition), element i tests one flag of condition field 32+i, given on bit i of the flag inputs. Code bits [2:1] select the flag: 00 less-than, 01 greater-than, 10 equal, 11 summary-overflow/unordered. Code bit 0 = 1 enables the element when the flag is clear.
- R7: Mask bits at index vl_i and above are 0. A vl_i above 64 behaves as 64, and vl_i = 0 gives an all-zero mask.
- R8: The destination mask follows dst_code_i and the source mask follows src_code_i. Both use the same mode, and each lane's result does not depend on the other lane's code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe; loads both masks |
| mode_i | input | 1 | 0 integer predication, 1 condition predication |
| dst_code_i | input | 3 | Selector code for the destination mask |
| src_code_i | input | 3 | Selector code for the source mask |
| vl_i | input | 7 | Vector length, 0 to 64 effective |
| r3_i | input | 64 | Snapshot of r3 |
| r10_i | input | 64 | Snapshot of r10 |
| r30_i | input | 64 | Snapshot of r30 |
| cr_lt_i | input | 64 | Less-than flag of field 32+i on bit i |
| cr_gt_i | input | 64 | Greater-than flag of field 32+i on bit i |
| cr_eq_i | input | 64 | Equal flag of field 32+i on bit i |
| cr_so_i | input | 64 | Overflow/unordered flag of field 32+i on bit i |
| dst_mask_o | output | 64 | Registered destination enable mask |
| src_mask_o | output | 64 | Registered source enable mask |
| valid_o | output | 1 | High one cycle after a request |

## Verification
The assertions assume that every input is stable and known at the clock edge where req_i is high. They also compare the registered mask with the vector length held from that same edge, so they assume vl_i is sampled only together with the request. The stimulus drives all inputs on the falling edge and holds them across the loading edge. It pulses req_i for a single cycle and then changes the inputs with no request, to show that the masks hold. Random cases draw vector lengths up to 69 and r3 values up to 79 for the single-element code, so the clamping and out-of-range paths are exercised on purpose.

// File: rtl/pred_mask_pkg.sv
package pred_mask_pkg;
  typedef enum logic {
    PM_INT = 1'b0,
    PM_CR  = 1'b1
  } pmode_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'b00,
    SEL_LO   = 2'b01,
    SEL_MID  = 2'b10,
    SEL_HI   = 2'b11
  } psel_e;

  typedef enum logic [1:0] {
    FLAG_LT = 2'b00,
    FLAG_GT = 2'b01,
    FLAG_EQ = 2'b10,
    FLAG_SO = 2'b11
  } pflag_e;
endpackage

// File: rtl/pred_int_sel.sv
module pred_int_sel
  import pred_mask_pkg::*;
#(
  parameter int EL   = 64,
  parameter int XLEN = 64
) (
  input  logic [2:0]      code_i,
  input  logic [XLEN-1:0] r3_i,
  input  logic [XLEN-1:0] r10_i,
  input  logic [XLEN-1:0] r30_i,
  output logic [EL-1:0]   mask_o
);
  logic [EL-1:0] onehot;
  logic [EL-1:0] picked;
  psel_e         sel;

  assign sel = psel_e'(code_i[2:1]);

  // single-element decode: compare the full register, so large values hit nothing
  for (genvar i = 0; i < EL; i++) begin : g_hot
    assign onehot[i] = (r3_i == XLEN'(i));
  end

  always_comb begin
    unique case (sel)
      SEL_BASE: picked = code_i[0] ? onehot : {EL{1'b1}};
      SEL_LO:   picked = r3_i[EL-1:0];
      SEL_MID:  picked = r10_i[EL-1:0];
      default:  picked = r30_i[EL-1:0];
    endcase
    if (sel != SEL_BASE && code_i[0]) mask_o = ~picked;
    else                               mask_o = picked;
  end
endmodule

// File: rtl/pred_cr_sel.sv
module pred_cr_sel
  import pred_mask_pkg::*;
#(
  parameter int EL = 64
) (
  input  logic [2:0]    code_i,
  input  logic [EL-1:0] lt_i,
  input  logic [EL-1:0] gt_i,
  input  logic [EL-1:0] eq_i,
  input  logic [EL-1:0] so_i,
  output logic [EL-1:0] mask_o
);
  logic [EL-1:0] flag;

  always_comb begin
    unique case (pflag_e'(code_i[2:1]))
      FLAG_LT: flag = lt_i;
      FLAG_GT: flag = gt_i;
      FLAG_EQ: flag = eq_i;
      default: flag = so_i;
    endcase
    mask_o = code_i[0] ? ~flag : flag;
  end
endmodule

// File: rtl/pred_lane.sv
module pred_lane
  import pred_mask_pkg::*;
#(
  parameter int EL   = 64,
  parameter int XLEN = 64,
  parameter int VLW  = $clog2(EL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic            mode_i,
  input  logic [2:0]      code_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [XLEN-1:0] r3_i,
  input  logic [XLEN-1:0] r10_i,
  input  logic [XLEN-1:0] r30_i,
  input  logic [EL-1:0]   lt_i,
  input  logic [EL-1:0]   gt_i,
  input  logic [EL-1:0]   eq_i,
  input  logic [EL-1:0]   so_i,
  output logic [EL-1:0]   mask_o
);
  logic [EL-1:0] int_mask;
  logic [EL-1:0] cr_mask;
  logic [EL-1:0] vl_fill;
  logic [EL-1:0] next_mask;
  logic [EL-1:0] mask_q;

  pred_int_sel #(.EL(EL), .XLEN(XLEN)) u_int (
    .code_i(code_i), .r3_i(r3_i), .r10_i(r10_i), .r30_i(r30_i), .mask_o(int_mask)
  );

  pred_cr_sel #(.EL(EL)) u_cr (
    .code_i(code_i), .lt_i(lt_i), .gt_i(gt_i), .eq_i(eq_i), .so_i(so_i), .mask_o(cr_mask)
  );

  // lengths above EL saturate naturally: every index is below them
  always_comb begin
    for (int i = 0; i < EL; i++) vl_fill[i] = (int'(vl_i) > i);
  end

  assign next_mask = ((pmode_e'(mode_i) == PM_CR) ? cr_mask : int_mask) & vl_fill;

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (req_i) mask_q <= next_mask;
  end

  assign mask_o = mask_q;

  function automatic logic [EL-1:0] fill_of(input logic [VLW-1:0] v);
    logic [EL-1:0] f;
    for (int i = 0; i < EL; i++) f[i] = (int'(v) > i);
    return f;
  endfunction

  assert_hold_mask_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> $stable(mask_o));

  assert_tail_zero_R7: assert property (@(posedge clk) disable iff (rst)
    req_i |=> ((mask_o & ~fill_of($past(vl_i))) == '0));

  assert_all_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i && !mode_i && code_i == 3'b000) |=> (mask_o == fill_of($past(vl_i))));

  assert_single_hot_R4: assert property (@(posedge clk) disable iff (rst)
    (req_i && !mode_i && code_i == 3'b001) |=> $onehot0(mask_o));
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pred_mask_pkg::*;
#(
  parameter int EL    = 64,
  parameter int XLEN  = 64,
  parameter int LANES = 2,
  parameter int VLW   = $clog2(EL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic            mode_i,
  input  logic [2:0]      dst_code_i,
  input  logic [2:0]      src_code_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [XLEN-1:0] r3_i,
  input  logic [XLEN-1:0] r10_i,
  input  logic [XLEN-1:0] r30_i,
  input  logic [EL-1:0]   cr_lt_i,
  input  logic [EL-1:0]   cr_gt_i,
  input  logic [EL-1:0]   cr_eq_i,
  input  logic [EL-1:0]   cr_so_i,
  output logic [EL-1:0]   dst_mask_o,
  output logic [EL-1:0]   src_mask_o,
  output logic            valid_o
);
  logic [LANES-1:0][2:0]    codes;
  logic [LANES-1:0][EL-1:0] masks;
  logic                     valid_q;

  assign codes[0] = dst_code_i;
  assign codes[1] = src_code_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pred_lane #(.EL(EL), .XLEN(XLEN), .VLW(VLW)) u_lane (
      .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .code_i(codes[l]),
      .vl_i(vl_i), .r3_i(r3_i), .r10_i(r10_i), .r30_i(r30_i),
      .lt_i(cr_lt_i), .gt_i(cr_gt_i), .eq_i(cr_eq_i), .so_i(cr_so_i),
      .mask_o(masks[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= req_i;
  end

  assign dst_mask_o = masks[0];
  assign src_mask_o = masks[1];
  assign valid_o    = valid_q;

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> valid_o);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !valid_o);
endmodule

// File: tb/pred_mask_gen_test.sv
module pred_mask_gen_test;
  localparam int EL = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic        mode;
  logic [2:0]  dcode, scode;
  logic [6:0]  vl;
  logic [63:0] r3, r10, r30, lt, gt, eq, so;
  logic [63:0] dmask, smask;
  logic        valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pred_mask_gen uut (
    .clk(clk), .rst(rst), .req_i(req), .mode_i(mode),
    .dst_code_i(dcode), .src_code_i(scode), .vl_i(vl),
    .r3_i(r3), .r10_i(r10), .r30_i(r30),
    .cr_lt_i(lt), .cr_gt_i(gt), .cr_eq_i(eq), .cr_so_i(so),
    .dst_mask_o(dmask), .src_mask_o(smask), .valid_o(valid)
  );

  function automatic logic [63:0] expect_mask(input logic m, input logic [2:0] c);
    logic [63:0] r;
    for (int i = 0; i < EL; i++) begin
      logic b;
      if (!m) begin
        case (c[2:1])
          2'b00:   b = c[0] ? (r3 == 64'(i)) : 1'b1;
          2'b01:   b = r3[i] ^ c[0];
          2'b10:   b = r10[i] ^ c[0];
          default: b = r30[i] ^ c[0];
        endcase
      end else begin
        case (c[2:1])
          2'b00:   b = lt[i] ^ c[0];
          2'b01:   b = gt[i] ^ c[0];
          2'b10:   b = eq[i] ^ c[0];
          default: b = so[i] ^ c[0];
        endcase
      end
      r[i] = b && (int'(vl) > i);
    end
    return r;
  endfunction

  function automatic string tag_of(input logic m, input logic [2:0] c);
    if (m) return "R6";
    if (c == 3'b000) return "R3";
    if (c == 3'b001) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic pulse(input string t_dst, input string t_src);
    logic [63:0] ed, es;
    @(negedge clk);
    req = 1'b1;
    ed = expect_mask(mode, dcode);
    es = expect_mask(mode, scode);
    @(negedge clk);
    req = 1'b0;
    check("R2 valid", {63'd0, valid}, 64'd1);
    check(t_dst, dmask, ed);
    check(t_src, smask, es);
  endtask

  task automatic randomize_data();
    r3 = {$urandom, $urandom}; r10 = {$urandom, $urandom}; r30 = {$urandom, $urandom};
    lt = {$urandom, $urandom}; gt = {$urandom, $urandom};
    eq = {$urandom, $urandom}; so = {$urandom, $urandom};
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] hd, hs;
    void'($urandom(32'd1234));
    rst = 1'b1; req = 1'b0; mode = 1'b0; dcode = 3'd0; scode = 3'd0; vl = 7'd64;
    randomize_data();
    repeat (3) @(negedge clk);
    check("R1 valid", {63'd0, valid}, 64'd0);
    check("R1 dst", dmask, 64'd0);
    check("R1 src", smask, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid idle", {63'd0, valid}, 64'd0);
    check("R1 dst idle", dmask, 64'd0);

    // R3 all ones, full and partial length
    mode = 0; dcode = 3'b000; scode = 3'b000; vl = 7'd64;
    pulse("R3 full", "R3 full");
    vl = 7'd5;
    pulse("R7 short", "R7 short");
    vl = 7'd0;
    pulse("R7 zero", "R7 zero");
    vl = 7'd100;
    pulse("R7 over", "R7 over");
    check("R7 over direct", dmask, 64'hFFFF_FFFF_FFFF_FFFF);
    // R4 one-hot corners
    vl = 7'd64; dcode = 3'b001; scode = 3'b001;
    r3 = 64'd63; pulse("R4 top", "R4 top");
    check("R4 top direct", dmask, 64'h8000_0000_0000_0000);
    r3 = 64'd64; pulse("R4 out", "R4 out");
    check("R4 out direct", dmask, 64'd0);
    r3 = 64'h1_0000_0002; pulse("R4 wide", "R4 wide");
    r3 = 64'd10; vl = 7'd10; pulse("R7 hot at vl", "R7 hot at vl");
    // R8 independent lanes
    randomize_data(); vl = 7'd64;
    dcode = 3'b010; scode = 3'b111; pulse("R8 dst", "R8 src");
    mode = 1; dcode = 3'b100; scode = 3'b011; pulse("R8 cr dst", "R8 cr src");
    // R2 hold without request
    hd = dmask; hs = smask;
    @(negedge clk);
    randomize_data(); dcode = 3'b000; mode = 0;
    @(negedge clk);
    check("R2 hold valid", {63'd0, valid}, 64'd0);
    check("R2 hold dst", dmask, hd);
    check("R2 hold src", smask, hs);

    for (int n = 0; n < 400; n++) begin
      randomize_data();
      mode = 1'($urandom);
      dcode = 3'($urandom);
      scode = 3'($urandom);
      vl = 7'($urandom % 70);
      if ($urandom % 2) r3 = 64'($urandom % 80);
      pulse(tag_of(mode, dcode), tag_of(mode, scode));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule